// File: doc/BRIEF.md
# Multiplexed Flash Bus Controller

This block sits on the host side of a pin-reduced NOR flash bus and turns single-word requests from a local valid/ready interface into bus cycles. A request carries an address, write data and a direction bit. The controller time-shares one 16-bit address/data bus under an active-low address-valid strobe. It also drives active-low chip enable, output enable and write enable. When a transfer completes it returns a one-cycle response, which carries the read word for reads.

There are two bus modes, and the mode is chosen while reset is held. In split mode, the address bits above bit 15 go out on dedicated pins for the whole transfer, and only the low 16 bits share the bus. In fully shared mode, the upper half of the address goes out in a first strobe-low phase and the lower half in a second one, and the dedicated pins stay at zero. The memory captures each address word on the rising edge of the strobe, so the controller holds the word on the bus through that edge.

Each phase length is a parameter counted in clock cycles, with a minimum of one: strobe low, strobe high to data, read access wait and write pulse. A read releases the bus once the last address phase is over. A write keeps driving the bus until after write enable has risen again. Chip enable goes high between transfers, so the two sides never drive the bus at the same time.

Top module: `mux_flash_ctrl`

## Requirements
- R1: The mode input is sampled only while rstN is low (1 = fully shared, 0 = split); changes after reset have no effect. In fully shared mode flashAddrHi is zero at all times.
- R2: In split mode a transfer has exactly one strobe-low phase; the bus word captured at its rising edge is address bits 15:0, and flashAddrHi equals address bits ADDR_W-1:16.
- R3: In fully shared mode a transfer has exactly two strobe-low phases; the first captures address bits ADDR_W-1:16 (zero-extended to 16 bits), the second captures bits 15:0.
- R4: Each strobe-low phase lasts ADV_CYC cycles. During it, chip enable is low and the bus is driven. The bus word is unchanged and still driven in the cycle where the strobe rises.
- R5: A read holds output enable low for RD_CYC cycles with the bus released, captures flashAdqIn in the last of them, and returns that word on rspRdata with rspValid.
- R6: A write holds write enable low for WE_CYC cycles. The bus drives the write data throughout that time and in the cycle where write enable rises. Output enable stays high.
- R7: The controller never drives the bus while output enable is low. Chip enable is high in the cycle that carries rspValid and in the idle cycle that follows it.
- R8: reqReady is high only while idle (chip enable high). Each accepted request produces exactly one rspValid cycle, and reqReady is low while it is outstanding.
- R9: During reset, chip enable, the strobe, output enable and write enable are high, the bus is released, rspValid is low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeFull | input | 1 | Bus mode, sampled during reset (1 = fully shared) |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data, valid with rspValid on reads |
| flashAdqOut | output | 16 | Shared bus output value |
| flashAdqOe | output | 1 | Shared bus output enable (tristate control) |
| flashAdqIn | input | 16 | Shared bus input value |
| flashAddrHi | output | ADDR_W-16 | Dedicated upper address pins |
| flashAdvN | output | 1 | Address-valid strobe, active low |
| flashCeN | output | 1 | Chip enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashWeN | output | 1 | Write enable, active low |

## Verification
Every cycle, the assertions check the pin relations that must always hold. The bus is never driven while output enable is low. The bus is driven with chip enable low whenever the strobe is low. The bus word stays stable across each rising strobe edge. Write data is on the bus while write enable is low, and the dedicated pins stay zero in fully shared mode. Only the bench scenarios can show the rest: that the captured address words match the request in each mode, that the phase lengths equal their parameters, that read data makes the round trip, that the mode is ignored after reset, and that each request gets exactly one response.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  // Strobes from the sequencer to the datapath and pins.
  typedef struct packed {
    logic ceN;
    logic advN;
    logic oeN;
    logic weN;
    logic busOe;
    logic selHi;
    logic selData;
    logic load;
    logic capture;
    logic fullMode;
  } mfc_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_RD,
    ST_WR,
    ST_WRH,
    ST_END
  } mfc_state_t;

endpackage

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
#(
  parameter int ADV_CYC = 2,
  parameter int GAP_CYC = 2,
  parameter int RD_CYC  = 3,
  parameter int WE_CYC  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeFull,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output logic        rspValid,
  output mfc_strobe_t stb
);

  localparam int MAX_AB = (ADV_CYC > GAP_CYC) ? ADV_CYC : GAP_CYC;
  localparam int MAX_CD = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] ADV_LD = CNT_W'(ADV_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LD  = CNT_W'(WE_CYC - 1);

  mfc_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             hiPhase;
  logic             isWrite;
  logic             fullQ;
  logic             cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ   <= modeFull;
      state   <= ST_IDLE;
      cnt     <= '0;
      hiPhase <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_ADDR;
          hiPhase <= fullQ;
          isWrite <= reqWrite;
          cnt     <= ADV_LD;
        end
        ST_ADDR: if (cntDone) begin
          state <= ST_HOLD;
          cnt   <= hiPhase ? '0 : GAP_LD;
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cntDone) begin
          if (hiPhase) begin
            hiPhase <= 1'b0;
            state   <= ST_ADDR;
            cnt     <= ADV_LD;
          end else if (isWrite) begin
            state <= ST_WR;
            cnt   <= WE_LD;
          end else begin
            state <= ST_RD;
            cnt   <= RD_LD;
          end
        end else cnt <= cnt - 1'b1;
        ST_RD: if (cntDone) state <= ST_END;
               else cnt <= cnt - 1'b1;
        ST_WR: if (cntDone) state <= ST_WRH;
               else cnt <= cnt - 1'b1;
        ST_WRH: state <= ST_END;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.ceN      = (state == ST_IDLE) || (state == ST_END);
    stb.advN     = (state != ST_ADDR);
    stb.oeN      = (state != ST_RD);
    stb.weN      = (state != ST_WR);
    stb.busOe    = (state == ST_ADDR) || (state == ST_HOLD) ||
                   (state == ST_WR) || (state == ST_WRH);
    stb.selHi    = hiPhase;
    stb.selData  = (state == ST_WR) || (state == ST_WRH);
    stb.load     = (state == ST_IDLE) && reqValid;
    stb.capture  = (state == ST_RD) && cntDone;
    stb.fullMode = fullQ;
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_END);

endmodule

// File: rtl/mfc_datapath.sv
module mfc_datapath
  import mfc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mfc_strobe_t             stb,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [BUS_W-1:0]        reqWdata,
  input  logic [BUS_W-1:0]        busIn,
  output logic [BUS_W-1:0]        busOut,
  output logic [ADDR_W-BUS_W-1:0] addrHi,
  output logic [BUS_W-1:0]        rdata
);

  localparam int HI_W = ADDR_W - BUS_W;

  logic [ADDR_W-1:0] addrReg;
  logic [BUS_W-1:0]  wdReg;
  logic [BUS_W-1:0]  hiWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      wdReg   <= '0;
      rdata   <= '0;
    end else begin
      if (stb.load) begin
        addrReg <= reqAddr;
        wdReg   <= reqWdata;
      end
      if (stb.capture) rdata <= busIn;
    end
  end

  assign hiWord = BUS_W'(addrReg[ADDR_W-1:BUS_W]);

  always_comb begin
    if (stb.selData)    busOut = wdReg;
    else if (stb.selHi) busOut = hiWord;
    else                busOut = addrReg[BUS_W-1:0];
  end

  assign addrHi = stb.fullMode ? {HI_W{1'b0}} : addrReg[ADDR_W-1:BUS_W];

endmodule

// File: rtl/mux_flash_ctrl.sv
module mux_flash_ctrl
  import mfc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int ADV_CYC = 2,
  parameter int GAP_CYC = 2,
  parameter int RD_CYC  = 3,
  parameter int WE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeFull,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  output logic              rspValid,
  output logic [15:0]       rspRdata,
  output logic [15:0]       flashAdqOut,
  output logic              flashAdqOe,
  input  logic [15:0]       flashAdqIn,
  output logic [ADDR_W-17:0] flashAddrHi,
  output logic              flashAdvN,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN
);

  mfc_strobe_t stb;

  mfc_ctrl #(
    .ADV_CYC(ADV_CYC), .GAP_CYC(GAP_CYC), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeFull(modeFull), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqReady(reqReady), .rspValid(rspValid), .stb(stb)
  );

  mfc_datapath #(.ADDR_W(ADDR_W), .BUS_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busIn(flashAdqIn), .busOut(flashAdqOut),
    .addrHi(flashAddrHi), .rdata(rspRdata)
  );

  assign flashAdqOe = stb.busOe;
  assign flashAdvN  = stb.advN;
  assign flashCeN   = stb.ceN;
  assign flashOeN   = stb.oeN;
  assign flashWeN   = stb.weN;

endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeFull,
  input logic              reqReady,
  input logic              rspValid,
  input logic [15:0]       flashAdqOut,
  input logic              flashAdqOe,
  input logic [ADDR_W-17:0] flashAddrHi,
  input logic              flashAdvN,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic              flashWeN
);

  logic fullSeen;
  always_ff @(posedge clk) begin
    if (!rstN) fullSeen <= modeFull;
  end

  // R7: no contention with the memory
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> !flashAdqOe);

  // R7: chip enable high during the response cycle
  a_r7_ce_idle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> flashCeN);

  // R1: dedicated pins zero in fully shared mode
  a_r1_hi_zero: assert property (@(posedge clk) disable iff (!rstN)
    fullSeen |-> (flashAddrHi == '0));

  // R4: strobe low only with chip enabled and bus driven
  a_r4_adv_drive: assert property (@(posedge clk) disable iff (!rstN)
    !flashAdvN |-> (flashAdqOe && !flashCeN));

  // R4: address held through the rising strobe edge
  a_r4_adv_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashAdvN) |-> (flashAdqOe && $stable(flashAdqOut)));

  // R6: write data driven while write enable low, output enable high
  a_r6_we_drive: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> (flashAdqOe && flashOeN));

  // R6: data held through the rising write-enable edge
  a_r6_we_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> (flashAdqOe && $stable(flashAdqOut)));

  // R8: ready only while idle
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (flashCeN && !rspValid));

endmodule

bind mux_flash_ctrl mfc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeFull(modeFull), .reqReady(reqReady),
  .rspValid(rspValid), .flashAdqOut(flashAdqOut), .flashAdqOe(flashAdqOe),
  .flashAddrHi(flashAddrHi), .flashAdvN(flashAdvN), .flashCeN(flashCeN),
  .flashOeN(flashOeN), .flashWeN(flashWeN)
);

// File: tb/sim_mux_flash_ctrl.sv
`timescale 1ns/1ps
module sim_mux_flash_ctrl;

  localparam int AW   = 24;
  localparam int TADV = 2;
  localparam int TGAP = 2;
  localparam int TRD  = 3;
  localparam int TWE  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, modeFull = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, rspValid, flashAdqOe, flashAdvN, flashCeN, flashOeN, flashWeN;
  logic [15:0] rspRdata, flashAdqOut;
  logic [15:0] flashAdqIn = 16'h0;
  logic [AW-17:0] flashAddrHi;

  mux_flash_ctrl #(.ADDR_W(AW), .ADV_CYC(TADV), .GAP_CYC(TGAP),
                   .RD_CYC(TRD), .WE_CYC(TWE)) u0 (
    .clk(clk), .rstN(rstN), .modeFull(modeFull), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata),
    .flashAdqOut(flashAdqOut), .flashAdqOe(flashAdqOe), .flashAdqIn(flashAdqIn),
    .flashAddrHi(flashAddrHi), .flashAdvN(flashAdvN), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .flashWeN(flashWeN)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] flashMem [int];
  logic [15:0] expMem [int];

  // monitor state (flash side model)
  int nPh, curLow, lens[4], weLow, oeLow, rspCnt, contention;
  logic [15:0] caps[4];
  logic [AW-17:0] hiAtCap;
  logic [15:0] weData;
  logic prevAdv = 1'b1, prevWe = 1'b1;
  logic [31:0] modelAddr;
  logic modelFull;

  function automatic logic [15:0] hashFn(input logic [31:0] a);
    return a[15:0] ^ {a[7:0], a[23:16]} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] expRead(input logic [31:0] a);
    return expMem.exists(int'(a)) ? expMem[int'(a)] : hashFn(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (!flashAdvN) curLow++;
      if (flashAdvN && !prevAdv && nPh < 4) begin
        lens[nPh] = curLow;
        caps[nPh] = flashAdqOut;
        if (nPh == 0) hiAtCap = flashAddrHi;
        nPh++;
        curLow = 0;
        if (modelFull && nPh == 2) modelAddr = {caps[0], caps[1]};
        else if (!modelFull && nPh == 1) modelAddr = {8'h0, flashAddrHi, caps[0]};
        flashAdqIn = flashMem.exists(int'(modelAddr)) ? flashMem[int'(modelAddr)]
                                                    : hashFn(modelAddr);
      end
      if (!flashWeN) weLow++;
      if (flashWeN && !prevWe) begin
        weData = flashAdqOut;
        flashMem[int'(modelAddr)] = flashAdqOut;
      end
      if (!flashOeN) oeLow++;
      if (!flashOeN && flashAdqOe) contention++;
      if (rspValid) rspCnt++;
      prevAdv = flashAdvN;
      prevWe  = flashWeN;
    end
  end

  task automatic doReset(input logic m);
    @(negedge clk);
    rstN = 1'b0; modeFull = m; modelFull = m;
    repeat (3) @(negedge clk);
    #1;
    chk(flashCeN && flashAdvN && flashOeN && flashWeN && !flashAdqOe && !rspValid
        && reqReady, "R9 reset pins", {flashCeN, flashAdvN, flashOeN, flashWeN,
        flashAdqOe, rspValid, reqReady}, 7'b1111001);
    @(negedge clk);
    rstN = 1'b1;
    modeFull = ~m;  // R1: must be ignored from here on
  endtask

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [15:0] d);
    logic [31:0] ea;
    int t;
    @(posedge clk); #1;
    nPh = 0; curLow = 0; weLow = 0; oeLow = 0; rspCnt = 0; contention = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;
    ea = 32'(a);
    t = 0;
    #1;
    while (!rspValid && t < 100) begin @(negedge clk); #1; t++; end
    chk(rspValid, "R8 response arrives", 32'(rspValid), 1);
    chk(!reqReady && flashCeN, "R8/R7 busy and ce high at response",
        {reqReady, flashCeN}, 2'b01);
    if (modelFull) begin
      chk(nPh == 2, "R3 two strobe phases", nPh, 2);
      chk(caps[0] == 16'(a[AW-1:16]), "R3 upper half first", caps[0], a[AW-1:16]);
      chk(caps[1] == a[15:0], "R3 lower half second", caps[1], a[15:0]);
      chk(hiAtCap == '0 && flashAddrHi == '0, "R1 upper pins zero", hiAtCap, 0);
      chk(lens[0] == TADV && lens[1] == TADV, "R4 strobe length",
          lens[0] * 100 + lens[1], TADV * 101);
    end else begin
      chk(nPh == 1, "R2 one strobe phase", nPh, 1);
      chk(caps[0] == a[15:0], "R2 low address on bus", caps[0], a[15:0]);
      chk(hiAtCap == a[AW-1:16], "R2 upper address pins", hiAtCap, a[AW-1:16]);
      chk(lens[0] == TADV, "R4 strobe length", lens[0], TADV);
    end
    chk(contention == 0, "R7 no contention", contention, 0);
    if (wr) begin
      chk(weLow == TWE, "R6 write pulse length", weLow, TWE);
      chk(weData == d, "R6 write data at edge", weData, d);
      chk(oeLow == 0, "R6 output enable high", oeLow, 0);
      expMem[int'(ea)] = d;
    end else begin
      chk(oeLow == TRD, "R5 read wait length", oeLow, TRD);
      chk(rspRdata == expRead(ea), "R5 read data", rspRdata, expRead(ea));
      chk(weLow == 0, "R5 no write pulse", weLow, 0);
    end
    @(negedge clk); #1;
    chk(flashCeN && !rspValid && reqReady && rspCnt == 1, "R7/R8 idle after response",
        {flashCeN, rspValid, reqReady, 8'(rspCnt)}, {3'b101, 8'd1});
  endtask

  task automatic runMode(input logic m);
    logic [AW-1:0] pool[4];
    logic [AW-1:0] a;
    doReset(m);
    // directed corners
    xfer(1'b0, '0, 16'h0);
    xfer(1'b0, '1, 16'h0);
    xfer(1'b1, 24'hA5_1234, 16'hBEEF);
    xfer(1'b0, 24'hA5_1234, 16'h0);
    xfer(1'b1, '1, 16'hFFFF);
    xfer(1'b0, '1, 16'h0);
    for (int i = 0; i < 4; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 40; i++) begin
      a = ($urandom % 2) ? pool[$urandom % 4] : AW'($urandom);
      xfer(1'($urandom), a, 16'($urandom));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    runMode(1'b0);
    expMem.delete(); flashMem.delete();
    runMode(1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule